// File: doc/BRIEF.md
# Bipolar Line Encoder with Violation Injection

This block turns a serial transmit bit stream into the two-rail drive of a bipolar line. It has a positive rail and a negative rail. Ones become marks that alternate in polarity and zeros become spaces. A format select changes the output to single-rail NRZ. A width select chooses full-cell or half-cell marks. The block runs on a clock at twice the bit rate, so every bit cell lasts exactly two clock cycles. An internal phase register marks the first and second half of each cell, and half-width pulses are shaped from that phase.

The bit stream comes in over a valid/ready interface. The block cannot stall the line, so `s_ready` rises for one cycle at the start of every cell, and that is the only back-pressure it applies. A source that is not valid at that moment leaves the cell empty, and the cell is sent as a space. A bit offered while `s_ready` is low waits for the next cell start. The source may never deliver more than one bit per cell.

A test control injects a single deliberate bipolar violation. A rising edge on `bpv_insert` arms the injector. The armed injector then waits for a run of three consecutive ones and gives the third one the same polarity as the mark before it. After that, alternation resumes from the violating mark. Each rising edge produces at most one violation.

Top module: `bipolar_line_encoder`

## Requirements
- R1: `s_ready` is high in the first cycle after reset and then in every second cycle. A bit is accepted when `s_valid && s_ready`. A cell with no valid bit at its start is sent as a 0 (space).
- R2: In bipolar format (`fmt_nrz`=0), an accepted 1 drives a mark on exactly one rail, with the polarity opposite to the previous mark. A 0 leaves both rails low. The rails take the new cell's value in the cycle after the accepting edge.
- R3: With `width_half`=0, a mark stays on its rail for both cycles of the cell.
- R4: With `width_half`=1 in bipolar format, a mark is present only in the first cycle of the cell, and both rails are low in the second cycle.
- R5: `line_pos` and `line_neg` are never high at the same time.
- R6: In NRZ format (`fmt_nrz`=1), `line_pos` carries the bit level for the whole cell whatever the width select, and `line_neg` stays low.
- R7: Format and width are sampled at the cell start and apply to the whole cell. Changes made during the second cycle of a cell have no effect on that cell.
- R8: Only a 0-to-1 change of `bpv_insert`, as sampled on successive clock edges, arms the injector. Holding the input high arms nothing more. The history bit resets to 0.
- R9: While armed, the first accepted 1 that follows at least two consecutive accepted 1s is sent with the same polarity as the previous mark. Later marks alternate from that mark. In NRZ format the violation is used up with no visible effect.
- R10: Any cell carrying a 0, including an empty cell, clears the run of consecutive ones.
- R11: Each arming produces at most one violation, and the armed state clears when the violation is sent. A second violation needs `bpv_insert` to go low and then high again.
- R12: Reset drives both rails low, clears the armed state and the run count, and sets the polarity history so that the first mark goes on `line_pos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Source has a bit to send |
| s_data | input | 1 | Bit value |
| s_ready | output | 1 | High at each cell start; the bit is taken when valid is also high |
| fmt_nrz | input | 1 | 0 = bipolar on both rails, 1 = NRZ on positive rail |
| width_half | input | 1 | 0 = full-cell marks, 1 = half-cell marks |
| bpv_insert | input | 1 | A rising edge arms one bipolar violation |
| line_pos | output | 1 | Positive rail drive |
| line_neg | output | 1 | Negative rail drive |

## Verification
The hardest case to reach is a violation that lands exactly where the rules put it. This needs a rising edge on the insert control, then three accepted ones with no empty cell or zero between them, and it must not be confused with ones that came before the arming. The directed part of the stimulus arms the injector before a long run of ones, holds the control high to show that nothing more happens, arms again in front of a run that a zero breaks, and arms in the middle of a run that has already passed three. The random part toggles the insert control rarely, over a stream of mostly ones with occasional idle cells and changes of format and width. A per-cycle bench model predicts every rail value and checks it.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

  // Output format of one bit cell
  typedef enum logic {
    FMT_BIPOLAR = 1'b0,
    FMT_NRZ     = 1'b1
  } lenc_fmt_e;

  // Width of a mark inside the cell
  typedef enum logic {
    WID_FULL = 1'b0,
    WID_HALF = 1'b1
  } lenc_wid_e;

  // Settings latched at the start of a cell
  typedef struct packed {
    lenc_fmt_e fmt;
    lenc_wid_e wid;
  } lenc_cell_cfg_t;

  // Rail pair
  typedef struct packed {
    logic pos;
    logic neg;
  } lenc_rails_t;

  localparam lenc_rails_t RAILS_IDLE = '{pos: 1'b0, neg: 1'b0};

endpackage

// File: rtl/lenc_cell_timer.sv
// Two-phase cell timer: the 2x-rate enable that splits each bit cell into
// a first half (cell start) and a second half.
module lenc_cell_timer #(
  parameter int unsigned HALVES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic cell_start
);
  localparam int unsigned PH_W = (HALVES > 1) ? $clog2(HALVES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALVES - 1);

  logic [PH_W-1:0] ph_q;

  // Reset leaves the counter on its last phase, so the first cycle
  // after reset is a cell start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= PH_LAST;
    end else if (ph_q == PH_LAST) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + PH_W'(1);
    end
  end

  assign cell_start = (ph_q == PH_LAST);

endmodule

// File: rtl/lenc_bpv_arm.sv
// Violation arming: edge detect on the insert control, run counter of
// consecutive ones, and the one-shot armed flag.
module lenc_bpv_arm #(
  parameter int unsigned RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,       // cell start edge
  input  logic bit_in,     // bit of the cell (0 when idle)
  input  logic insert_in,  // raw insert control
  output logic fire        // this cell's mark is the violation
);
  localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(RUN_LEN - 1);

  logic             ins_q;
  logic             rise;
  logic             armed;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_d;
  logic             run_ok;

  assign rise = insert_in & ~ins_q;

  generate
    if (RUN_LEN <= 1) begin : g_no_run
      assign run_ok = 1'b1;
    end else begin : g_run
      assign run_ok = (run_q >= RUN_PRE);
    end
  endgenerate

  assign fire = armed & take & bit_in & run_ok;

  always_comb begin
    run_d = run_q;
    if (take) begin
      if (!bit_in) begin
        run_d = '0;
      end else if (run_q != RUN_MAX) begin
        run_d = run_q + RUN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_q <= 1'b0;
      armed <= 1'b0;
      run_q <= '0;
    end else begin
      ins_q <= insert_in;
      armed <= (armed & ~fire) | rise;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/lenc_ami_tracker.sv
// Mark polarity tracker: alternates on every mark, repeats on a violation.
module lenc_ami_tracker #(
  parameter bit FIRST_NEG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic bit_in,
  input  logic fire,
  output logic mark_neg   // polarity of the current cell's mark
);
  logic last_neg;

  assign mark_neg = fire ? last_neg : ~last_neg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_neg <= ~FIRST_NEG;
    end else if (take && bit_in) begin
      last_neg <= mark_neg;
    end
  end

endmodule

// File: rtl/lenc_rail_shaper.sv
// Rail shaping: latches cell settings and forms bipolar or NRZ output,
// full- or half-width.
module lenc_rail_shaper
  import lenc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           bit_in,
  input  logic           mark_neg,
  input  lenc_cell_cfg_t cfg_in,
  output logic           pos,
  output logic           neg
);
  lenc_cell_cfg_t cfg_q;
  lenc_rails_t    rails_q;
  lenc_rails_t    rails_new;
  lenc_rails_t    rails_d;
  logic           nrz_q;
  logic           half_q;

  assign nrz_q  = (cfg_q.fmt == FMT_NRZ);
  assign half_q = (cfg_q.wid == WID_HALF);

  always_comb begin
    if (cfg_in.fmt == FMT_NRZ) begin
      rails_new = '{pos: bit_in, neg: 1'b0};
    end else begin
      rails_new = '{pos: bit_in & ~mark_neg, neg: bit_in & mark_neg};
    end
  end

  always_comb begin
    rails_d = rails_q;
    if (take) begin
      rails_d = rails_new;
    end else if (half_q && !nrz_q) begin
      rails_d = RAILS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rails_q <= RAILS_IDLE;
      cfg_q   <= '{fmt: FMT_BIPOLAR, wid: WID_FULL};
    end else begin
      rails_q <= rails_d;
      if (take) begin
        cfg_q <= cfg_in;
      end
    end
  end

  assign pos = rails_q.pos;
  assign neg = rails_q.neg;

endmodule

// File: rtl/bipolar_line_encoder.sv
module bipolar_line_encoder
  import lenc_pkg::*;
#(
  parameter int unsigned RUN_LEN   = 3,
  parameter bit          FIRST_NEG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  input  logic s_data,
  output logic s_ready,
  input  logic fmt_nrz,
  input  logic width_half,
  input  logic bpv_insert,
  output logic line_pos,
  output logic line_neg
);
  localparam int unsigned CELL_HALVES = 2;

  logic           cell_start;
  logic           cell_bit;
  logic           bpv_fire;
  logic           mark_neg;
  lenc_cell_cfg_t cfg;

  lenc_cell_timer #(.HALVES(CELL_HALVES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_start (cell_start)
  );

  assign s_ready  = cell_start;
  // An empty cell is a space
  assign cell_bit = s_valid & s_data;
  assign cfg      = '{fmt: lenc_fmt_e'(fmt_nrz), wid: lenc_wid_e'(width_half)};

  lenc_bpv_arm #(.RUN_LEN(RUN_LEN)) u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (cell_start),
    .bit_in    (cell_bit),
    .insert_in (bpv_insert),
    .fire      (bpv_fire)
  );

  lenc_ami_tracker #(.FIRST_NEG(FIRST_NEG)) u_ami (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (cell_start),
    .bit_in   (cell_bit),
    .fire     (bpv_fire),
    .mark_neg (mark_neg)
  );

  lenc_rail_shaper u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (cell_start),
    .bit_in   (cell_bit),
    .mark_neg (mark_neg),
    .cfg_in   (cfg),
    .pos      (line_pos),
    .neg      (line_neg)
  );

endmodule

// File: rtl/lenc_checker.sv
module lenc_shape_checker (
  input logic clk,
  input logic rst_n,
  input logic take,
  input logic nrz_q,
  input logic half_q,
  input logic pos,
  input logic neg
);
  assert_cell_start_alt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  assert_cell_second_alt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> take);
  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && (!half_q || nrz_q)) |=> ($stable(pos) && $stable(neg)));
  assert_half_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && half_q && !nrz_q) |=> (!pos && !neg));
  assert_rails_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos && neg));
  assert_nrz_neg_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nrz_q |-> !neg);
endmodule

module lenc_arm_checker #(
  parameter int unsigned RUN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take,
  input logic             bit_in,
  input logic             rise,
  input logic             armed,
  input logic             fire,
  input logic [RUN_W-1:0] run_q
);
  assert_arm_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !fire) |=> armed);
  assert_zero_clears_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bit_in) |=> (run_q == '0));
  assert_single_shot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rise) |=> !armed);
endmodule

bind lenc_rail_shaper lenc_shape_checker u_shape_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .take   (take),
  .nrz_q  (nrz_q),
  .half_q (half_q),
  .pos    (pos),
  .neg    (neg)
);

bind lenc_bpv_arm lenc_arm_checker #(.RUN_W(RUN_W)) u_arm_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .take   (take),
  .bit_in (bit_in),
  .rise   (rise),
  .armed  (armed),
  .fire   (fire),
  .run_q  (run_q)
);

// File: tb/bipolar_line_encoder_tb.sv
module bipolar_line_encoder_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic s_valid, s_data, s_ready;
  logic fmt_nrz, width_half, bpv_insert;
  logic line_pos, line_neg;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // Bench model state
  bit      m_ph, m_last_neg, m_armed, m_insq, m_pos, m_neg, m_nrz, m_half;
  int      m_run;

  always #5 clk = ~clk;

  bipolar_line_encoder u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .s_ready    (s_ready),
    .fmt_nrz    (fmt_nrz),
    .width_half (width_half),
    .bpv_insert (bpv_insert),
    .line_pos   (line_pos),
    .line_neg   (line_neg)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_ph = 1; m_last_neg = 1; m_armed = 0; m_insq = 0;
    m_pos = 0; m_neg = 0; m_nrz = 0; m_half = 0; m_run = 0;
  endfunction

  function automatic void model_step(input bit v, input bit d, input bit f, input bit h, input bit i);
    bit rise, b, fire, nm;
    rise = i & ~m_insq;
    m_insq = i;
    if (m_ph) begin
      b = v & d;
      fire = m_armed && b && (m_run >= 2);
      nm = fire ? m_last_neg : ~m_last_neg;
      if (b) m_last_neg = nm;
      m_run = b ? ((m_run < 3) ? m_run + 1 : 3) : 0;
      m_armed = (m_armed && !fire) || rise;
      if (f) begin m_pos = b; m_neg = 0; end
      else begin m_pos = b & ~nm; m_neg = b & nm; end
      m_nrz = f; m_half = h; m_ph = 0;
    end else begin
      m_armed = m_armed || rise;
      if (m_half && !m_nrz) begin m_pos = 0; m_neg = 0; end
      m_ph = 1;
    end
  endfunction

  // One clock cycle, entered and left at a falling edge
  task automatic cyc(input bit v, input bit d, input bit f, input bit h, input bit i, input string tag);
    s_valid = v; s_data = d; fmt_nrz = f; width_half = h; bpv_insert = i;
    chk(s_ready, m_ph, "R1", "s_ready");
    model_step(v, d, f, h, i);
    @(posedge clk);
    @(negedge clk);
    chk(line_pos, m_pos, tag, "line_pos");
    chk(line_neg, m_neg, tag, "line_neg");
  endtask

  // One full bit cell
  task automatic send(input bit d, input bit f, input bit h, input bit i, input string tag);
    cyc(1, d, f, h, i, tag);
    cyc(0, 0, f, h, i, tag);
  endtask

  initial begin
    rst_n = 0; s_valid = 0; s_data = 0; fmt_nrz = 0; width_half = 0; bpv_insert = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk(line_pos, 1'b0, "R12", "reset line_pos");
    chk(line_neg, 1'b0, "R12", "reset line_neg");
    rst_n = 1;

    // R12 / R2: first mark on positive rail, then alternation, zero = space
    send(1, 0, 0, 0, "R12");
    chk(line_pos, 1'b1, "R12", "first mark positive (second half)");
    send(1, 0, 0, 0, "R2");
    send(0, 0, 0, 0, "R2");
    send(1, 0, 0, 0, "R3");
    send(1, 0, 0, 0, "R3");
    // R4 half width
    for (int k = 0; k < 4; k++) send(k != 2, 0, 1, 0, "R4");
    // R6 NRZ, both widths
    for (int k = 0; k < 4; k++) send(k[0], 1, k[1], 0, "R6");
    // R1 empty cells and a bit offered off-cell
    cyc(0, 1, 0, 0, 0, "R1");
    cyc(1, 1, 0, 0, 0, "R1");
    send(1, 0, 0, 0, "R1");
    // R7 settings change mid-cell ignored
    cyc(1, 1, 0, 0, 0, "R7");
    cyc(0, 0, 1, 1, 0, "R7");
    cyc(1, 1, 0, 1, 0, "R7");
    cyc(0, 0, 0, 0, 0, "R7");
    // R9 arm then run of ones
    send(0, 0, 0, 1, "R9");
    for (int k = 0; k < 6; k++) send(1, 0, 0, 1, "R9");
    // R8 / R11 hold high: no more violations
    for (int k = 0; k < 6; k++) send(1, 0, 0, 1, "R11");
    // R10 re-arm, run broken by a zero
    send(0, 0, 0, 0, "R10");
    send(1, 0, 0, 1, "R10");
    send(1, 0, 0, 1, "R10");
    send(0, 0, 0, 1, "R10");
    for (int k = 0; k < 4; k++) send(1, 0, 1, 1, "R10");
    // R9 arm in the middle of a long run
    cyc(1, 1, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 1, "R9");
    for (int k = 0; k < 4; k++) send(1, 0, 0, 1, "R9");
    // R8 rise and fall within a cell
    send(0, 0, 0, 0, "R8");
    cyc(1, 1, 0, 0, 1, "R8");
    cyc(0, 0, 0, 0, 0, "R8");
    for (int k = 0; k < 4; k++) send(1, 0, 0, 0, "R8");

    // Random traffic
    void'($urandom(32'h5eed_1234));
    begin
      bit f = 0, h = 0, ins = 0;
      for (int k = 0; k < 6000; k++) begin
        if ($urandom % 64 == 0) f = ~f;
        if ($urandom % 32 == 0) h = ~h;
        if ($urandom % 20 == 0) ins = ~ins;
        cyc(($urandom % 8) != 0, ($urandom % 4) != 0, f, h, ins, "R2 R5 R7 R9");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    done = 1;
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule